// File: doc/BRIEF.md
# Banked GPIO Register Interface

This block is the register core of a general-purpose I/O controller with up to 128 pins. The pins are split into four banks of 32, and pin n belongs to bank n>>5 at bit n&31. Each bank holds a direction word, an output latch, a shadow copy of the last value written to the set port, and two alternate-function words. Software reaches these through a simple synchronous register bus that uses byte addresses. The address map is sparse: the first three banks sit at the bottom of the window, and the fourth bank's level, direction, set and clear registers sit in a separate window starting at 0x100.

Software never writes the output latch directly. It writes to a set port, which ORs bits into the latch, or to a clear port, which removes bits from it. Each pin drives its latch bit only when its direction bit is 1. A level read returns the driven value for output pins and the synchronized pin input for input pins. Edge detection, interrupts and pad muxing belong to other blocks.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset, all direction, output-latch, set-shadow and alternate-function words are zero, so `pin_oe_o` and `pin_out_o` are all zero and `err_o` is low.
- R2: A write to a bank's set port (bank0 0x018, bank1 0x01C, bank2 0x020) ORs the write data into that bank's output latch. The result appears on `pin_out_o` one cycle after the write, for pins whose direction bit is 1.
- R3: A write to a bank's clear port (bank0 0x024, bank1 0x028, bank2 0x02C) clears each latch bit where the write data is 1 and leaves the other bits unchanged.
- R4: Writing a direction word (bank0 0x00C, bank1 0x010, bank2 0x014) replaces it. For every pin, `pin_oe_o` equals the direction bit and `pin_out_o` equals the latch bit ANDed with the direction bit.
- R5: Reading a level word (bank0 0x000, bank1 0x004, bank2 0x008) returns, bit by bit, the latch where the direction bit is 1 and `pin_in_i` where the direction bit is 0.
- R6: Reading a set port returns the value most recently written to that set port.
- R7: The alternate-function words read back what was written. The low words are at 0x054/0x05C/0x064/0x06C and the upper words at 0x058/0x060/0x068/0x070, for banks 0 to 3 in that order.
- R8: Any access at byte address 0x200 or above reads zero, changes no state and does not raise `err_o`.
- R9: An access below 0x200 that hits no register reads zero, changes no state and pulses `err_o` high for exactly the cycle after the access. This covers misaligned addresses and the unused range 0x030 to 0x050.
- R10: Pin indices at or above parameter `LINES` are not implemented. Their direction, latch, set-shadow and level bits read zero, and their `pin_oe_o` and `pin_out_o` stay zero.
- R11: Read data is registered. `rdata_o` updates in the cycle after `re_i` is sampled and holds its value while `re_i` is low.
- R12: Bank 3 uses level 0x100, direction 0x10C, set 0x118 and clear 0x124, and these behave exactly like the other banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | One-cycle pulse on an unmapped access below 0x200 |
| pin_in_i | input | 128 | Synchronized pin inputs |
| pin_out_o | output | 128 | Per-pin output value |
| pin_oe_o | output | 128 | Per-pin output enable |

## Verification
Every result of the block is due exactly one clock edge after the stimulus. A write changes `pin_out_o` and `pin_oe_o` at the next edge. A read loads `rdata_o` at the next edge, and an unmapped access raises `err_o` at the next edge and drops it one edge later. The bench drives the bus on the falling edge and samples at the following falling edge, so each check lands on the cycle where the result is due. For the `err_o` pulse it samples one more falling edge to confirm the flag has cleared. Direction and latch state that no output pin exposes is read back through the level and direction registers, so every write that must have no effect is verified at the ports.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;
  localparam int BANK_W    = 32;
  localparam int NUM_BANKS = 4;

  typedef enum logic [2:0] {
    K_NONE, K_LEVEL, K_DIR, K_SET, K_CLR, K_AFL, K_AFU
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [1:0] bank;
    logic       far;
  } dec_t;

  // implemented-bit mask for bank b given the pin count
  function automatic logic [BANK_W-1:0] lane_mask(int lines, int b);
    logic [BANK_W-1:0] m;
    for (int i = 0; i < BANK_W; i++) m[i] = ((b * BANK_W + i) < lines);
    return m;
  endfunction
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_regs_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);
  logic [8:0] off;
  int         w;
  int         idx;

  assign off = addr_i[8:0];

  always_comb begin
    dec_o      = '0;
    dec_o.kind = K_NONE;
    w          = int'(off[8:2]);
    idx        = 0;
    if ((addr_i >> 9) != '0) begin
      dec_o.far = 1'b1;
    end else if (off[1:0] != 2'b00) begin
      dec_o.kind = K_NONE;
    end else if (off[8]) begin
      dec_o.bank = 2'd3;
      case (off[7:0])
        8'h00:   dec_o.kind = K_LEVEL;
        8'h0C:   dec_o.kind = K_DIR;
        8'h18:   dec_o.kind = K_SET;
        8'h24:   dec_o.kind = K_CLR;
        default: dec_o.kind = K_NONE;
      endcase
    end else if (w < 12) begin
      // three banks per register group, groups in level/dir/set/clr order
      dec_o.bank = 2'(w % 3);
      case (w / 3)
        0:       dec_o.kind = K_LEVEL;
        1:       dec_o.kind = K_DIR;
        2:       dec_o.kind = K_SET;
        default: dec_o.kind = K_CLR;
      endcase
    end else if (w >= 21 && w <= 28) begin
      idx        = w - 21;
      dec_o.bank = 2'(idx >> 1);
      dec_o.kind = idx[0] ? K_AFU : K_AFL;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_regs_pkg::*;
#(
  parameter logic [BANK_W-1:0] IMPL_MASK = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  reg_kind_e         wr_kind_i,
  input  logic [BANK_W-1:0] wdata_i,
  input  logic [BANK_W-1:0] pin_in_i,
  output logic [BANK_W-1:0] dir_o,
  output logic [BANK_W-1:0] olat_o,
  output logic [BANK_W-1:0] set_shadow_o,
  output logic [BANK_W-1:0] afl_o,
  output logic [BANK_W-1:0] afu_o,
  output logic [BANK_W-1:0] level_o
);
  logic [BANK_W-1:0] wmask;
  assign wmask = wdata_i & IMPL_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o        <= '0;
      olat_o       <= '0;
      set_shadow_o <= '0;
      afl_o        <= '0;
      afu_o        <= '0;
    end else if (wr_en_i) begin
      case (wr_kind_i)
        K_DIR: dir_o <= wmask;
        K_SET: begin
          olat_o       <= olat_o | wmask;
          set_shadow_o <= wmask;
        end
        K_CLR:   olat_o <= olat_o & ~wmask;
        K_AFL:   afl_o  <= wdata_i;
        K_AFU:   afu_o  <= wdata_i;
        default: ;
      endcase
    end
  end

  assign level_o = ((olat_o & dir_o) | (pin_in_i & ~dir_o)) & IMPL_MASK;
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_regs_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LINES  = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  input  logic              re_i,
  output logic [31:0]       rdata_o,
  output logic              err_o,
  input  logic [127:0]      pin_in_i,
  output logic [127:0]      pin_out_o,
  output logic [127:0]      pin_oe_o
);
  localparam int NPINS = NUM_BANKS * BANK_W;

  dec_t              dec;
  logic              hit;
  logic [BANK_W-1:0] dir_w   [NUM_BANKS];
  logic [BANK_W-1:0] olat_w  [NUM_BANKS];
  logic [BANK_W-1:0] shad_w  [NUM_BANKS];
  logic [BANK_W-1:0] afl_w   [NUM_BANKS];
  logic [BANK_W-1:0] afu_w   [NUM_BANKS];
  logic [BANK_W-1:0] level_w [NUM_BANKS];
  logic [31:0]       rd_mux;

  gpio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .dec_o  (dec)
  );

  assign hit = (dec.kind != K_NONE);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_bank #(.IMPL_MASK(lane_mask(LINES, b))) u_bank (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .wr_en_i      (we_i && hit && (dec.bank == 2'(b))),
      .wr_kind_i    (dec.kind),
      .wdata_i      (wdata_i),
      .pin_in_i     (pin_in_i[b*BANK_W +: BANK_W]),
      .dir_o        (dir_w[b]),
      .olat_o       (olat_w[b]),
      .set_shadow_o (shad_w[b]),
      .afl_o        (afl_w[b]),
      .afu_o        (afu_w[b]),
      .level_o      (level_w[b])
    );
    assign pin_oe_o[b*BANK_W +: BANK_W]  = dir_w[b];
    assign pin_out_o[b*BANK_W +: BANK_W] = olat_w[b] & dir_w[b];
  end

  always_comb begin
    case (dec.kind)
      K_LEVEL: rd_mux = level_w[dec.bank];
      K_DIR:   rd_mux = dir_w[dec.bank];
      K_SET:   rd_mux = shad_w[dec.bank];
      K_AFL:   rd_mux = afl_w[dec.bank];
      K_AFU:   rd_mux = afu_w[dec.bank];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      if (re_i) rdata_o <= rd_mux;
      err_o <= (re_i || we_i) && !hit && !dec.far;
    end
  end

  if (NPINS != 128) begin : g_bad_width
    initial $error("bank geometry must cover 128 pins");
  end
endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk #(
  parameter int ADDR_W = 10,
  parameter int LINES  = 128
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic              re_i,
  input logic [31:0]       rdata_o,
  input logic              err_o,
  input logic [127:0]      pin_out_o,
  input logic [127:0]      pin_oe_o
);
  logic far;
  assign far = (addr_i >> 9) != '0;

  AST_OUT_WITHIN_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_out_o & ~pin_oe_o) == '0); // R4
  AST_IDLE_PINS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(pin_oe_o) && $stable(pin_out_o))); // R2
  AST_FAR_WRITE_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && far) |=> ($stable(pin_oe_o) && $stable(pin_out_o))); // R8
  AST_FAR_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && far) |=> (rdata_o == '0)); // R8
  AST_FAR_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((re_i || we_i) && far) |=> !err_o); // R8
  AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(re_i || we_i)); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o)); // R11

  if (LINES < 128) begin : g_unimpl
    AST_UNIMPL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pin_oe_o[127:LINES] == '0) && (pin_out_o[127:LINES] == '0)); // R10
  end
endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(.ADDR_W(ADDR_W), .LINES(LINES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .we_i      (we_i),
  .re_i      (re_i),
  .rdata_o   (rdata_o),
  .err_o     (err_o),
  .pin_out_o (pin_out_o),
  .pin_oe_o  (pin_oe_o)
);

// File: tb/tb_gpio_bank_regs.sv
module tb_gpio_bank_regs;
  localparam int ADDR_W = 10;
  localparam int LINES  = 100;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              we = 1'b0;
  logic [31:0]       wdata = '0;
  logic              re = 1'b0;
  logic [31:0]       rdata;
  logic              err;
  logic [127:0]      pin_in = '0;
  logic [127:0]      pin_out;
  logic [127:0]      pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_bank_regs #(.ADDR_W(ADDR_W), .LINES(LINES)) dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .addr_i    (addr),
    .we_i      (we),
    .wdata_i   (wdata),
    .re_i      (re),
    .rdata_o   (rdata),
    .err_o     (err),
    .pin_in_i  (pin_in),
    .pin_out_o (pin_out),
    .pin_oe_o  (pin_oe)
  );

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive on falling edge; result sampled at the next falling edge
  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, output logic e);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    e = err;
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    d = rdata; e = err;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic e;
    chk("R1 oe after reset", pin_oe, '0);
    chk("R1 out after reset", pin_out, '0);
    chk("R1 err after reset", {127'b0, err}, '0);
    bus_rd(10'h00C, d, e);
    chk("R1 dir0 after reset", {96'b0, d}, '0);
    bus_rd(10'h018, d, e);
    chk("R1 set shadow after reset", {96'b0, d}, '0);
  endtask

  task automatic t_set_clear();
    logic [31:0] d; logic e;
    bus_wr(10'h00C, 32'h0000FFFF, e);
    chk("R4 oe follows dir", pin_oe[31:0], 32'h0000FFFF);
    bus_wr(10'h018, 32'h00FF00FF, e);
    chk("R2 set ORs, masked by dir", pin_out[31:0], 32'h000000FF);
    bus_wr(10'h018, 32'h00000100, e);
    chk("R2 second set accumulates", pin_out[31:0], 32'h000001FF);
    bus_wr(10'h024, 32'h0000010F, e);
    chk("R3 clear removes bits", pin_out[31:0], 32'h000000F0);
    bus_rd(10'h018, d, e);
    chk("R6 set readback", d, 32'h00000100);
    bus_wr(10'h00C, 32'hFFFFFFFF, e);
    chk("R4 latch revealed by dir", pin_out[31:0], 32'h00FF00F0);
  endtask

  task automatic t_level();
    logic [31:0] d; logic e;
    bus_wr(10'h00C, 32'h0000FFFF, e);
    pin_in[31:0] = 32'hA5A5A5A5;
    bus_rd(10'h000, d, e);
    chk("R5 level merge bank0", d, 32'hA5A500F0);
    pin_in[63:32] = 32'h12345678;
    bus_wr(10'h010, 32'hFF000000, e);
    bus_wr(10'h01C, 32'hFFFFFFFF, e);
    chk("R2 bank1 set", pin_out[63:32], 32'hFF000000);
    bus_rd(10'h004, d, e);
    chk("R5 level merge bank1", d, 32'hFF345678);
    bus_wr(10'h014, 32'h0000000F, e);
    bus_wr(10'h020, 32'h00000005, e);
    chk("R4 bank2 out", pin_out[95:64], 32'h00000005);
  endtask

  task automatic t_bank3();
    logic [31:0] d; logic e;
    bus_wr(10'h10C, 32'hFFFFFFFF, e);
    bus_rd(10'h10C, d, e);
    chk("R10 R12 bank3 dir masked", d, 32'h0000000F);
    chk("R10 unimpl oe zero", {100'b0, pin_oe[127:100]}, '0);
    bus_wr(10'h118, 32'hFFFFFFFF, e);
    chk("R12 bank3 set", pin_out[127:96], 32'h0000000F);
    bus_rd(10'h118, d, e);
    chk("R10 shadow masked", d, 32'h0000000F);
    bus_wr(10'h124, 32'h00000003, e);
    chk("R12 bank3 clear", pin_out[127:96], 32'h0000000C);
    bus_wr(10'h10C, 32'h0000000A, e);
    pin_in[127:96] = 32'hFFFFFFF5;
    bus_rd(10'h100, d, e);
    chk("R12 R10 bank3 level", d, 32'h0000000D);
  endtask

  task automatic t_altfn();
    logic [31:0] d; logic e;
    for (int i = 0; i < 8; i++) begin
      bus_wr(ADDR_W'(10'h054 + 4 * i), 32'hC0DE0000 + 32'(i), e);
    end
    for (int i = 0; i < 8; i++) begin
      bus_rd(ADDR_W'(10'h054 + 4 * i), d, e);
      chk("R7 alt-function word", d, 32'hC0DE0000 + 32'(i));
    end
  endtask

  task automatic t_far();
    logic [31:0] d; logic e;
    logic [127:0] oe0, out0;
    oe0 = pin_oe; out0 = pin_out;
    bus_wr(10'h20C, 32'hFFFFFFFF, e);
    chk("R8 far write no err", {127'b0, e}, '0);
    bus_wr(10'h218, 32'hFFFFFFFF, e);
    chk("R8 far write no effect oe", pin_oe, oe0);
    chk("R8 far write no effect out", pin_out, out0);
    bus_rd(10'h200, d, e);
    chk("R8 far read zero", d, 32'h0);
    chk("R8 far read no err", {127'b0, e}, '0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d, d0; logic e;
    bus_rd(10'h00C, d0, e);
    bus_rd(10'h030, d, e);
    chk("R9 unmapped read zero", d, 32'h0);
    chk("R9 unmapped read err", {127'b0, e}, 128'd1);
    @(negedge clk);
    chk("R9 err one cycle", {127'b0, err}, '0);
    bus_wr(10'h00E, 32'hFFFFFFFF, e);
    chk("R9 misaligned write err", {127'b0, e}, 128'd1);
    bus_wr(10'h04C, 32'hFFFFFFFF, e);
    bus_rd(10'h00C, d, e);
    chk("R9 unmapped write no effect", d, d0);
    chk("R9 mapped read no err", {127'b0, e}, '0);
  endtask

  task automatic t_hold();
    logic [31:0] d; logic e;
    bus_rd(10'h010, d, e);
    chk("R11 read value", d, 32'hFF000000);
    addr = 10'h00C;
    repeat (3) @(negedge clk);
    chk("R11 rdata held while idle", rdata, 32'hFF000000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_clear();
    t_level();
    t_bank3();
    t_altfn();
    t_far();
    t_unmapped();
    t_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule